// File: doc/BRIEF.md
# Bus Software-Reset Call Detector

This block sits behind a serial-bus byte decoder and recognises the general software-reset call. The decoder hands it a start strobe, a stop strobe, and a strobe for every received byte, with a flag that marks the byte as the address byte of the transfer. For each byte the detector decides whether the device should acknowledge it. This lets the bus master see at once whether the call is going through. The block does not sample bus bits or clear any registers itself.

The call has a fixed shape. It begins with the reserved address byte 06h, which is the 7-bit address 0000011 with a write bit. Two key bytes follow: A5h first, then 5Ah. A stop must come last. Only when this shape is met does the block raise a single-cycle reset pulse for the rest of the device. Any byte out of place is not acknowledged and quietly abandons the attempt. A start strobe, whether at the head of a transfer or repeated in the middle of one, clears all progress.

Top module: `bus_reset_call_detector`

## Requirements
- R1: An address-phase byte equal to 06h (address bits [7:1] = 0000011, bit 0 = R/W = 0) is acknowledged; `ack_out` is high in the clock cycle after the `byte_vld` strobe and low otherwise.
- R2: An address-phase byte equal to 07h (the call address with R/W = 1) is not acknowledged, the data bytes after it are not acknowledged, and the following stop gives no reset pulse.
- R3: An address-phase byte other than 06h is not acknowledged, and the data bytes of that transfer are not acknowledged.
- R4: After an acknowledged call address, the first data byte is acknowledged only if it equals A5h; any other value is not acknowledged and ends the attempt.
- R5: The second data byte is acknowledged only if it equals 5Ah; any other value, including the keys in the wrong order, is not acknowledged and ends the attempt.
- R6: Every data byte after the second key is not acknowledged, and a stop after such an extra byte gives no reset pulse.
- R7: A stop that follows the two correct keys raises `reset_pulse` for exactly one clock cycle, the cycle after the `stop_stb` strobe; a stop in any other situation gives no pulse.
- R8: A start strobe, including a repeated start in the middle of a call, returns the detector to idle without a reset pulse; a later well-formed call still works.
- R9: With `rst_n` low at a clock edge, both outputs are low at the next cycle and all sequence progress is discarded.
- R10: A data byte received without a prior acknowledged call address (for example after a stop) is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_stb | input | 1 | One-cycle strobe on a start or repeated start |
| stop_stb | input | 1 | One-cycle strobe on a stop |
| byte_vld | input | 1 | One-cycle strobe: `byte_data` holds a received byte |
| byte_data | input | 8 | Received byte |
| addr_phase | input | 1 | High when the strobed byte is the address byte |
| ack_out | output | 1 | Acknowledge decision for the previous strobed byte |
| reset_pulse | output | 1 | One-cycle device reset request |

## Verification
The hardest situation to reach is a stop that arrives after the two keys, where the call has already been ruined earlier. This happens after a repeated start in the middle of the call, after an extra byte, or after a reset in the middle of the call. These cases look almost the same as a good call. Stimulus reaches them with sequences that replay the full good call up to the point where it goes wrong, each placed just before or just after a clean call. This shows that the state is discarded, not simply left stuck. The bench also checks that the pulse is low in the cycle after it fires, and that a reset applied while the call is armed removes the pulse.

// File: rtl/swr_pkg.sv
// Package: shared types for the software-reset call detector.
// Assumes: one phase variable plus a key index fully describe progress.
package swr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,  // no call in progress
        PH_KEYS  = 2'd1,  // call address accepted, collecting keys
        PH_ARMED = 2'd2,  // all keys accepted, waiting for stop
        PH_DEAD  = 2'd3   // attempt abandoned until next start
    } swr_phase_e;

endpackage

// File: rtl/swr_byte_match.sv
// Module: compares the incoming byte against the call address and
// every key of the handshake in parallel.
// Assumes: KEYS packs key 0 (first expected) in the low slice.
module swr_byte_match #(
    parameter int                          DATA_W    = 8,
    parameter int                          KEY_COUNT = 2,
    parameter logic [DATA_W-1:0]           CALL_ADDR = 8'h06,
    parameter logic [KEY_COUNT*DATA_W-1:0] KEYS      = {8'h5A, 8'hA5}
) (
    input  logic [DATA_W-1:0]    byte_data,
    output logic                 addr_hit,
    output logic [KEY_COUNT-1:0] key_hit
);

    // Address compare includes the R/W bit, so a read call never hits.
    always_comb addr_hit = (byte_data == CALL_ADDR);

    // One comparator per key position.
    for (genvar k = 0; k < KEY_COUNT; k++) begin : g_key
        assign key_hit[k] = (byte_data == KEYS[k*DATA_W +: DATA_W]);
    end

endmodule

// File: rtl/swr_seq_fsm.sv
// Module: tracks progress through the call and makes the per-byte
// acknowledge decision, registered one cycle after the byte strobe.
// Assumes: start, stop and byte strobes never coincide; start wins
// if they do.
module swr_seq_fsm
    import swr_pkg::*;
#(
    parameter int KEY_COUNT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_stb,
    input  logic                 stop_stb,
    input  logic                 byte_vld,
    input  logic                 addr_phase,
    input  logic                 addr_hit,
    input  logic [KEY_COUNT-1:0] key_hit,
    output logic                 ack_q,
    output logic                 fire
);

    localparam int                IDX_W    = (KEY_COUNT > 1) ? $clog2(KEY_COUNT) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_COUNT - 1);

    swr_phase_e       phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             ack_d;

    // Next-state and acknowledge decision.
    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        ack_d   = 1'b0;
        if (start_stb) begin
            phase_d = PH_IDLE;
            idx_d   = '0;
        end else if (stop_stb) begin
            phase_d = PH_IDLE;
            idx_d   = '0;
        end else if (byte_vld && addr_phase) begin
            idx_d = '0;
            if (addr_hit) begin
                phase_d = PH_KEYS;
                ack_d   = 1'b1;
            end else begin
                phase_d = PH_IDLE;
            end
        end else if (byte_vld) begin
            case (phase_q)
                PH_KEYS: begin
                    if (key_hit[idx_q]) begin
                        ack_d = 1'b1;
                        if (idx_q == LAST_IDX) phase_d = PH_ARMED;
                        else                   idx_d   = idx_q + 1'b1;
                    end else begin
                        phase_d = PH_DEAD;
                    end
                end
                PH_ARMED: phase_d = PH_DEAD;
                default:  phase_d = phase_q;
            endcase
        end
    end

    // State, key index and acknowledge registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            ack_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
            ack_q   <= ack_d;
        end
    end

    // Stop seen while armed and no start in the same cycle.
    always_comb fire = stop_stb && !start_stb && (phase_q == PH_ARMED);

endmodule

// File: rtl/swr_pulse_gen.sv
// Module: registers the completion condition into the one-cycle
// reset pulse.
// Assumes: fire is never high two cycles in a row (the FSM leaves
// the armed phase on stop).
module swr_pulse_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic reset_pulse
);

    // One register stage between the stop strobe and the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) reset_pulse <= 1'b0;
        else        reset_pulse <= fire;
    end

endmodule

// File: rtl/bus_reset_call_detector.sv
// Module: top of the software-reset call detector. It watches decoded
// bus events, decides the acknowledge for each byte, and issues a
// reset pulse after a well-formed call closed by stop.
// Assumes: strobes come from an upstream byte decoder, one cycle each.
module bus_reset_call_detector #(
    parameter int                          DATA_W    = 8,
    parameter int                          KEY_COUNT = 2,
    parameter logic [DATA_W-1:0]           CALL_ADDR = 8'h06,
    parameter logic [KEY_COUNT*DATA_W-1:0] KEYS      = {8'h5A, 8'hA5}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_stb,
    input  logic              stop_stb,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              addr_phase,
    output logic              ack_out,
    output logic              reset_pulse
);

    logic                 addr_hit;
    logic [KEY_COUNT-1:0] key_hit;
    logic                 fire;

    swr_byte_match #(
        .DATA_W   (DATA_W),
        .KEY_COUNT(KEY_COUNT),
        .CALL_ADDR(CALL_ADDR),
        .KEYS     (KEYS)
    ) u_match (
        .byte_data(byte_data),
        .addr_hit (addr_hit),
        .key_hit  (key_hit)
    );

    swr_seq_fsm #(
        .KEY_COUNT(KEY_COUNT)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_stb (start_stb),
        .stop_stb  (stop_stb),
        .byte_vld  (byte_vld),
        .addr_phase(addr_phase),
        .addr_hit  (addr_hit),
        .key_hit   (key_hit),
        .ack_q     (ack_out),
        .fire      (fire)
    );

    swr_pulse_gen u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .reset_pulse(reset_pulse)
    );

endmodule

// File: rtl/swr_checker.sv
// Module: property checker for the detector, attached by bind.
// Assumes: at most one strobe per cycle from the upstream decoder.
module swr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_stb,
    input logic       stop_stb,
    input logic       byte_vld,
    input logic [7:0] byte_data,
    input logic       addr_phase,
    input logic       ack_out,
    input logic       reset_pulse
);

    AST_ACK_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_out |-> $past(byte_vld)); // R1

    AST_READ_CALL_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && addr_phase && byte_data == 8'h07) |=> !ack_out); // R2

    AST_FOREIGN_ADDR_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && addr_phase && byte_data != 8'h06) |=> !ack_out); // R3

    AST_PULSE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> $past(stop_stb)); // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |=> !reset_pulse); // R7

    AST_START_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> !reset_pulse); // R8

    AST_NO_ACK_ON_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_stb || stop_stb) |=> !ack_out); // R10

endmodule

bind bus_reset_call_detector swr_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_stb  (start_stb),
    .stop_stb   (stop_stb),
    .byte_vld   (byte_vld),
    .byte_data  (byte_data),
    .addr_phase (addr_phase),
    .ack_out    (ack_out),
    .reset_pulse(reset_pulse)
);

// File: tb/sim_bus_reset_call_detector.sv
module sim_bus_reset_call_detector;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_stb = 1'b0, stop_stb = 1'b0, byte_vld = 1'b0, addr_phase = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       ack_out, reset_pulse;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    bus_reset_call_detector u0 (
        .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .stop_stb(stop_stb),
        .byte_vld(byte_vld), .byte_data(byte_data), .addr_phase(addr_phase),
        .ack_out(ack_out), .reset_pulse(reset_pulse)
    );

    // Vector fields: {op[1:0], byte[7:0], expect, req[3:0]}
    // op 0 = start, 1 = address byte, 2 = data byte, 3 = stop.
    localparam int NV = 56;
    localparam logic [14:0] VEC [NV] = '{
        {2'd2, 8'hA5, 1'b0, 4'd10},  // R10 data byte while idle
        {2'd0, 8'h00, 1'b0, 4'd8},   // good call
        {2'd1, 8'h06, 1'b1, 4'd1},   // R1
        {2'd2, 8'hA5, 1'b1, 4'd4},   // R4
        {2'd2, 8'h5A, 1'b1, 4'd5},   // R5
        {2'd3, 8'h00, 1'b1, 4'd7},   // R7
        {2'd0, 8'h00, 1'b0, 4'd8},   // read call
        {2'd1, 8'h07, 1'b0, 4'd2},   // R2
        {2'd2, 8'hA5, 1'b0, 4'd2},
        {2'd2, 8'h5A, 1'b0, 4'd2},
        {2'd3, 8'h00, 1'b0, 4'd2},
        {2'd0, 8'h00, 1'b0, 4'd8},   // wrong first key
        {2'd1, 8'h06, 1'b1, 4'd1},
        {2'd2, 8'hA4, 1'b0, 4'd4},   // R4
        {2'd2, 8'h5A, 1'b0, 4'd4},
        {2'd3, 8'h00, 1'b0, 4'd4},
        {2'd0, 8'h00, 1'b0, 4'd8},   // wrong second key
        {2'd1, 8'h06, 1'b1, 4'd1},
        {2'd2, 8'hA5, 1'b1, 4'd4},
        {2'd2, 8'h5B, 1'b0, 4'd5},   // R5
        {2'd3, 8'h00, 1'b0, 4'd5},
        {2'd0, 8'h00, 1'b0, 4'd8},   // extra byte
        {2'd1, 8'h06, 1'b1, 4'd1},
        {2'd2, 8'hA5, 1'b1, 4'd4},
        {2'd2, 8'h5A, 1'b1, 4'd5},
        {2'd2, 8'h00, 1'b0, 4'd6},   // R6
        {2'd3, 8'h00, 1'b0, 4'd6},
        {2'd0, 8'h00, 1'b0, 4'd8},   // repeated start mid-call
        {2'd1, 8'h06, 1'b1, 4'd1},
        {2'd2, 8'hA5, 1'b1, 4'd4},
        {2'd0, 8'h00, 1'b0, 4'd8},   // R8
        {2'd1, 8'h06, 1'b1, 4'd8},
        {2'd2, 8'hA5, 1'b1, 4'd8},
        {2'd2, 8'h5A, 1'b1, 4'd8},
        {2'd3, 8'h00, 1'b1, 4'd8},
        {2'd0, 8'h00, 1'b0, 4'd8},   // repeated start while armed
        {2'd1, 8'h06, 1'b1, 4'd1},
        {2'd2, 8'hA5, 1'b1, 4'd4},
        {2'd2, 8'h5A, 1'b1, 4'd5},
        {2'd0, 8'h00, 1'b0, 4'd8},
        {2'd3, 8'h00, 1'b0, 4'd8},   // R8 no pulse
        {2'd0, 8'h00, 1'b0, 4'd8},   // foreign address
        {2'd1, 8'hC0, 1'b0, 4'd3},   // R3
        {2'd2, 8'hA5, 1'b0, 4'd3},
        {2'd2, 8'h5A, 1'b0, 4'd3},
        {2'd3, 8'h00, 1'b0, 4'd3},
        {2'd0, 8'h00, 1'b0, 4'd8},   // keys swapped
        {2'd1, 8'h06, 1'b1, 4'd1},
        {2'd2, 8'h5A, 1'b0, 4'd5},
        {2'd2, 8'hA5, 1'b0, 4'd5},
        {2'd3, 8'h00, 1'b0, 4'd5},
        {2'd2, 8'hA5, 1'b0, 4'd10},  // R10 after stop
        {2'd0, 8'h00, 1'b0, 4'd8},   // clean call at the end
        {2'd1, 8'h06, 1'b1, 4'd1},
        {2'd2, 8'hA5, 1'b1, 4'd4},
        {2'd2, 8'h5A, 1'b1, 4'd5}
    };

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Drive one event for one cycle, then sample in the following cycle.
    task automatic apply(input logic [1:0] op, input logic [7:0] b);
        start_stb  = (op == 2'd0);
        addr_phase = (op == 2'd1);
        byte_vld   = (op == 2'd1) || (op == 2'd2);
        stop_stb   = (op == 2'd3);
        byte_data  = b;
        @(negedge clk);
        start_stb = 1'b0; addr_phase = 1'b0; byte_vld = 1'b0; stop_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9", "ack_out in reset", ack_out, 1'b0);
        check("R9", "reset_pulse in reset", reset_pulse, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [7:0] b;
            logic       e;
            string      tag;
            op  = VEC[i][14:13];
            b   = VEC[i][12:5];
            e   = VEC[i][4];
            tag = $sformatf("R%0d vec %0d", VEC[i][3:0], i);
            apply(op, b);
            check(tag, "ack_out", ack_out, (op == 2'd1 || op == 2'd2) ? e : 1'b0);
            check(tag, "reset_pulse", reset_pulse, (op == 2'd3) ? e : 1'b0);
        end

        // R7 pulse lasts one cycle: the table ends armed.
        apply(2'd3, 8'h00);
        check("R7", "pulse after stop", reset_pulse, 1'b1);
        @(negedge clk);
        check("R7", "pulse second cycle", reset_pulse, 1'b0);

        // R9 reset while armed discards progress.
        apply(2'd0, 8'h00);
        apply(2'd1, 8'h06);
        apply(2'd2, 8'hA5);
        apply(2'd2, 8'h5A);
        check("R9", "ack before reset", ack_out, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", "ack cleared by reset", ack_out, 1'b0);
        rst_n = 1'b1;
        apply(2'd3, 8'h00);
        check("R9", "no pulse after reset", reset_pulse, 1'b0);

        // R7 stop with no call at all.
        apply(2'd3, 8'h00);
        check("R7", "bare stop", reset_pulse, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule